// File: doc/BRIEF.md
# Used Ring Completion and Interrupt Gate

This block retires finished requests of one virtual queue into the used ring kept in shared memory, and decides whether the driver should be interrupted. A completion command writes an element into the ring slot selected by the running used index. The element holds the head descriptor id and the total byte count. The running index then advances. That index stays private until a sync command publishes it to the ring header. After publishing, the sync reads the available-ring flags and either raises the queue interrupt or counts a skipped one. A third command turns driver kicks on or off by read-modify-writing the used-ring flags.

The block reaches memory through one 32-bit request/acknowledge port with byte enables. The ring header is a single word: the flags halfword is in bits 15:0 and the used index is in bits 31:16. Elements are 8 bytes, the id word first and the length word second, and they begin 4 bytes past the header. The controller is a state machine with these states:
- `ST_IDLE`: waits for a command.
- `ST_PUT_ID` and `ST_PUT_LEN`: write the two words of an element.
- `ST_PUB_IDX`: writes the used index into the header.
- `ST_GET_AFLG`: reads the available flags and makes the interrupt decision.
- `ST_KICK_RD` and `ST_KICK_WR`: read and rewrite the header flags.

Transitions out of `ST_IDLE` depend on the opcode: a completion goes to `ST_PUT_ID`, a sync to `ST_PUB_IDX`, a kick command to `ST_KICK_RD`, and the reserved opcode stays in `ST_IDLE`. Each other state advances when its access is acknowledged, along these chains:
- `ST_PUT_ID` → `ST_PUT_LEN` → `ST_IDLE`
- `ST_PUB_IDX` → `ST_GET_AFLG` → `ST_IDLE`
- `ST_KICK_RD` → `ST_KICK_WR` → `ST_IDLE`

Top module: `usedring_retire`

## Requirements
- R1: After reset `cmd_ready` is 1 and `mem_req`, `irq`, `isr`, both counters and `next_used` are all 0.
- R2: Opcode 2'b00 (complete) writes `cmd_id` to address used_base+4+8*slot and then `cmd_len` to used_base+8+8*slot, both with byte enables 4'b1111. Here slot is `next_used` modulo 2^`cfg_ring_log2`. After the second write `next_used` increases by one, and the header word is left unchanged.
- R3: Opcode 2'b01 (sync) writes `next_used` into bits 31:16 of the header word at used_base, using byte enables 4'b1100, so the flags half is preserved.
- R4: After publishing, the sync reads the word at `cfg_avail_base`. If bit 0 (no-interrupt) is clear, an interrupt is raised.
- R5: If that bit 0 is set, an interrupt is still raised when `cfg_notify_empty` and `queue_empty` are both 1.
- R6: A sync that raises increments `cnt_raised` by one. A sync that does not raise increments `cnt_skipped` by one instead. No other command changes either counter.
- R7: A raise sets `isr` bit 0 (the queue cause) and drives `irq` high. Both stay set until `isr_clear` is pulsed. If a raise lands in the same cycle as the clear, the raise wins.
- R8: Opcode 2'b10 reads the header word and writes it back with byte enables 4'b0011. Bit 0 (no-notify) is written as the inverse of `cmd_kick_en`, and bits 15:1 keep the values that were read.
- R9: A command is taken only while `cmd_ready` is 1. Opcode 2'b11 is accepted but causes no memory access and changes no output.
- R10: Once raised, `mem_req` and its address, write flag, byte enables and data are held until `mem_ack`. A completion therefore makes exactly two writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Opcode: 00 complete, 01 sync, 10 kick control, 11 reserved |
| cmd_id | input | 32 | Head descriptor id for a completion |
| cmd_len | input | 32 | Total byte count for a completion |
| cmd_kick_en | input | 1 | 1 enables driver kicks, 0 suppresses them |
| cmd_ready | output | 1 | Controller idle and able to take a command |
| cfg_used_base | input | 32 | Byte address of the used-ring header |
| cfg_avail_base | input | 32 | Byte address of the available-ring flags word |
| cfg_ring_log2 | input | 4 | Log2 of the ring size |
| cfg_notify_empty | input | 1 | Notify-on-empty feature negotiated |
| queue_empty | input | 1 | Available ring holds no unconsumed entries |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| isr_clear | input | 1 | Clears the interrupt status and lowers the line |
| irq | output | 1 | Interrupt line |
| isr | output | 8 | Interrupt status; bit 0 is the queue cause |
| cnt_raised | output | 16 | Raised-interrupt count |
| cnt_skipped | output | 16 | Skipped-interrupt count |
| next_used | output | 16 | Running used index |

## Verification
The assertions assume the memory side acknowledges only a pending request, and returns one `mem_ack` pulse per access. They also assume `isr_clear` is pulsed only while the controller sits idle, or deliberately alongside a decision. The bench responder keeps to these rules. It services a request only while `mem_req` is high and drops the acknowledge the cycle after. Its latency rotates from zero to two extra cycles, so the hold rule is exercised. The configuration and `queue_empty` are changed only between commands.

// File: rtl/usedring_pkg.sv
package usedring_pkg;
    typedef enum logic [1:0] {
        OP_PUT  = 2'b00,
        OP_SYNC = 2'b01,
        OP_KICK = 2'b10,
        OP_NOP  = 2'b11
    } uop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUT_ID,
        ST_PUT_LEN,
        ST_PUB_IDX,
        ST_GET_AFLG,
        ST_KICK_RD,
        ST_KICK_WR
    } ustate_e;

    localparam int HDR_BYTES  = 4;
    localparam int ELEM_SHIFT = 3;
endpackage

// File: rtl/usedring_addr.sv
module usedring_addr
    import usedring_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 16
) (
    input  ustate_e          st,
    input  logic [AW-1:0]    used_base,
    input  logic [AW-1:0]    avail_base,
    input  logic [3:0]       ring_log2,
    input  logic [IDX_W-1:0] next_used,
    output logic [AW-1:0]    addr
);
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] slot;
    logic [AW-1:0]    elem_addr;

    always_comb begin
        mask      = IDX_W'((IDX_W'(1) << ring_log2) - IDX_W'(1));
        slot      = next_used & mask;
        elem_addr = used_base + AW'(HDR_BYTES) + (AW'(slot) << ELEM_SHIFT);
    end

    always_comb begin
        unique case (st)
            ST_PUT_ID:   addr = elem_addr;
            ST_PUT_LEN:  addr = elem_addr + AW'(4);
            ST_GET_AFLG: addr = avail_base;
            default:     addr = used_base;
        endcase
    end
endmodule

// File: rtl/usedring_irq.sv
module usedring_irq #(
    parameter int CNT_W = 16,
    parameter int ISR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raise,
    input  logic             skip,
    input  logic             isr_clear,
    output logic             irq,
    output logic [ISR_W-1:0] isr,
    output logic [CNT_W-1:0] cnt_raised,
    output logic [CNT_W-1:0] cnt_skipped
);
    localparam logic [ISR_W-1:0] QUEUE_CAUSE = ISR_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq         <= 1'b0;
            isr         <= '0;
            cnt_raised  <= '0;
            cnt_skipped <= '0;
        end else begin
            if (raise) begin
                isr        <= isr | QUEUE_CAUSE;
                irq        <= 1'b1;
                cnt_raised <= cnt_raised + CNT_W'(1);
            end else if (isr_clear) begin
                isr <= '0;
                irq <= 1'b0;
            end
            if (skip) begin
                cnt_skipped <= cnt_skipped + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/usedring_fsm.sv
module usedring_fsm
    import usedring_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [DW-1:0]    cmd_id,
    input  logic [DW-1:0]    cmd_len,
    input  logic             cmd_kick_en,
    input  logic             notify_empty,
    input  logic             queue_empty,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output ustate_e          st,
    output logic             cmd_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [DW/8-1:0]  mem_be,
    output logic [DW-1:0]    mem_wdata,
    output logic             raise,
    output logic             skip,
    output logic [IDX_W-1:0] next_used
);
    localparam int HALF = DW / 2;
    localparam int BEW  = DW / 8;

    ustate_e       st_nx;
    logic [DW-1:0] id_q;
    logic [DW-1:0] len_q;
    logic          kick_q;
    logic [DW-1:0] hdr_q;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (uop_e'(cmd_op))
                        OP_PUT:  st_nx = ST_PUT_ID;
                        OP_SYNC: st_nx = ST_PUB_IDX;
                        OP_KICK: st_nx = ST_KICK_RD;
                        OP_NOP:  st_nx = ST_IDLE;
                    endcase
                end
            end
            ST_PUT_ID:   if (mem_ack) st_nx = ST_PUT_LEN;
            ST_PUT_LEN:  if (mem_ack) st_nx = ST_IDLE;
            ST_PUB_IDX:  if (mem_ack) st_nx = ST_GET_AFLG;
            ST_GET_AFLG: if (mem_ack) st_nx = ST_IDLE;
            ST_KICK_RD:  if (mem_ack) st_nx = ST_KICK_WR;
            ST_KICK_WR:  if (mem_ack) st_nx = ST_IDLE;
            default:     st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            id_q      <= '0;
            len_q     <= '0;
            kick_q    <= 1'b0;
            hdr_q     <= '0;
            next_used <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_IDLE && cmd_valid) begin
                id_q   <= cmd_id;
                len_q  <= cmd_len;
                kick_q <= cmd_kick_en;
            end
            if (st == ST_KICK_RD && mem_ack) begin
                hdr_q <= mem_rdata;
            end
            if (st == ST_PUT_LEN && mem_ack) begin
                next_used <= next_used + IDX_W'(1);
            end
        end
    end

    always_comb begin
        cmd_ready = (st == ST_IDLE);
        mem_req   = (st != ST_IDLE);
        mem_we    = 1'b0;
        mem_be    = '1;
        mem_wdata = '0;
        raise     = 1'b0;
        skip      = 1'b0;
        unique case (st)
            ST_PUT_ID: begin
                mem_we    = 1'b1;
                mem_wdata = id_q;
            end
            ST_PUT_LEN: begin
                mem_we    = 1'b1;
                mem_wdata = len_q;
            end
            ST_PUB_IDX: begin
                mem_we    = 1'b1;
                mem_be    = {{(BEW/2){1'b1}}, {(BEW/2){1'b0}}};
                mem_wdata = {HALF'(next_used), {HALF{1'b0}}};
            end
            ST_GET_AFLG: begin
                if (mem_ack) begin
                    raise = !mem_rdata[0] || (notify_empty && queue_empty);
                    skip  = !raise;
                end
            end
            ST_KICK_WR: begin
                mem_we    = 1'b1;
                mem_be    = {{(BEW/2){1'b0}}, {(BEW/2){1'b1}}};
                mem_wdata = {hdr_q[DW-1:1], !kick_q};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/usedring_retire.sv
module usedring_retire
    import usedring_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int IDX_W = 16,
    parameter int CNT_W = 16,
    parameter int ISR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [DW-1:0]    cmd_id,
    input  logic [DW-1:0]    cmd_len,
    input  logic             cmd_kick_en,
    output logic             cmd_ready,
    input  logic [AW-1:0]    cfg_used_base,
    input  logic [AW-1:0]    cfg_avail_base,
    input  logic [3:0]       cfg_ring_log2,
    input  logic             cfg_notify_empty,
    input  logic             queue_empty,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW/8-1:0]  mem_be,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             isr_clear,
    output logic             irq,
    output logic [ISR_W-1:0] isr,
    output logic [CNT_W-1:0] cnt_raised,
    output logic [CNT_W-1:0] cnt_skipped,
    output logic [IDX_W-1:0] next_used
);
    ustate_e st;
    logic    raise;
    logic    skip;

    usedring_fsm #(.DW(DW), .IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_id       (cmd_id),
        .cmd_len      (cmd_len),
        .cmd_kick_en  (cmd_kick_en),
        .notify_empty (cfg_notify_empty),
        .queue_empty  (queue_empty),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .st           (st),
        .cmd_ready    (cmd_ready),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_be       (mem_be),
        .mem_wdata    (mem_wdata),
        .raise        (raise),
        .skip         (skip),
        .next_used    (next_used)
    );

    usedring_addr #(.AW(AW), .IDX_W(IDX_W)) u_addr (
        .st         (st),
        .used_base  (cfg_used_base),
        .avail_base (cfg_avail_base),
        .ring_log2  (cfg_ring_log2),
        .next_used  (next_used),
        .addr       (mem_addr)
    );

    usedring_irq #(.CNT_W(CNT_W), .ISR_W(ISR_W)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .raise       (raise),
        .skip        (skip),
        .isr_clear   (isr_clear),
        .irq         (irq),
        .isr         (isr),
        .cnt_raised  (cnt_raised),
        .cnt_skipped (cnt_skipped)
    );
endmodule

// File: rtl/usedring_retire_chk.sv
module usedring_retire_chk #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int IDX_W = 16,
    parameter int CNT_W = 16,
    parameter int ISR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic [DW/8-1:0]  mem_be,
    input logic [DW-1:0]    mem_wdata,
    input logic             mem_ack,
    input logic             isr_clear,
    input logic             irq,
    input logic [ISR_W-1:0] isr,
    input logic [CNT_W-1:0] cnt_raised,
    input logic [CNT_W-1:0] cnt_skipped,
    input logic [IDX_W-1:0] next_used
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_req); // R9
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be) && $stable(mem_wdata))); // R10
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> isr[0]); // R7
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_clear && cmd_ready) |=> (!irq && isr == '0)); // R7
    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(next_used) |-> next_used == IDX_W'($past(next_used) + IDX_W'(1))); // R2
    AST_RAISE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_raised) |-> (cnt_raised == CNT_W'($past(cnt_raised) + CNT_W'(1)) && $stable(cnt_skipped))); // R6
    AST_SKIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt_skipped) |-> (cnt_skipped == CNT_W'($past(cnt_skipped) + CNT_W'(1)) && !$rose(irq))); // R6
endmodule

bind usedring_retire usedring_retire_chk #(
    .AW(AW), .DW(DW), .IDX_W(IDX_W), .CNT_W(CNT_W), .ISR_W(ISR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ready   (cmd_ready),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .isr_clear   (isr_clear),
    .irq         (irq),
    .isr         (isr),
    .cnt_raised  (cnt_raised),
    .cnt_skipped (cnt_skipped),
    .next_used   (next_used)
);

// File: tb/usedring_retire_test.sv
`timescale 1ns/1ps
module usedring_retire_test;
    localparam logic [31:0] UB = 32'h0000_1000;
    localparam logic [31:0] AB = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [31:0] cmd_id = '0;
    logic [31:0] cmd_len = '0;
    logic        cmd_kick_en = 1'b0;
    logic        cmd_ready;
    logic [3:0]  cfg_ring_log2 = 4'd2;
    logic        cfg_notify_empty = 1'b0;
    logic        queue_empty = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        isr_clear = 1'b0;
    logic        irq;
    logic [7:0]  isr;
    logic [15:0] cnt_raised, cnt_skipped, next_used;

    int checks = 0;
    int fails = 0;
    int wr_count = 0;
    int svc = 0;
    int wait_cnt = 0;
    logic [31:0] mem [int unsigned];

    int exp_next = 0, exp_raised = 0, exp_skipped = 0;
    logic exp_irq = 1'b0;
    logic [7:0] exp_isr = '0;

    always #2.5 clk = ~clk;

    usedring_retire uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_id(cmd_id), .cmd_len(cmd_len), .cmd_kick_en(cmd_kick_en),
        .cmd_ready(cmd_ready), .cfg_used_base(UB), .cfg_avail_base(AB),
        .cfg_ring_log2(cfg_ring_log2), .cfg_notify_empty(cfg_notify_empty),
        .queue_empty(queue_empty), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .isr_clear(isr_clear),
        .irq(irq), .isr(isr), .cnt_raised(cnt_raised),
        .cnt_skipped(cnt_skipped), .next_used(next_used)
    );

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a >> 2) ? mem[a >> 2] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // memory responder, latency rotating 0..2 extra cycles
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wait_cnt < (svc % 3)) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    svc++;
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        logic [31:0] w;
                        w = rd(mem_addr);
                        for (int b = 0; b < 4; b++)
                            if (mem_be[b]) w[b*8 +: 8] = mem_wdata[b*8 +: 8];
                        mem[mem_addr >> 2] = w;
                        wr_count++;
                    end else begin
                        mem_rdata = rd(mem_addr);
                    end
                end
            end
        end
    end

    // reference comparison on every idle clock
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cmd_ready) begin
                chk(irq == exp_irq, "R7 irq", 32'(irq), 32'(exp_irq));
                chk(isr == exp_isr, "R7 isr", 32'(isr), 32'(exp_isr));
                chk(cnt_raised == 16'(exp_raised), "R6 raised", 32'(cnt_raised), 32'(exp_raised));
                chk(cnt_skipped == 16'(exp_skipped), "R6 skipped", 32'(cnt_skipped), 32'(exp_skipped));
                chk(next_used == 16'(exp_next), "R2 next_used", 32'(next_used), 32'(exp_next));
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] op, input logic [31:0] id, input logic [31:0] len, input logic ken);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_len = len; cmd_kick_en = ken;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        if (op == 2'b00) exp_next = (exp_next + 1) % 65536;
        if (op == 2'b01) begin
            if (!rd(AB)[0] || (cfg_notify_empty && queue_empty)) begin
                exp_raised++; exp_irq = 1'b1; exp_isr = exp_isr | 8'h01;
            end else begin
                exp_skipped++;
            end
        end
        wait_idle();
    endtask

    task automatic put_check(input logic [31:0] id, input logic [31:0] len, input string tag);
        int slot;
        int w0;
        logic [31:0] hdr;
        slot = exp_next % (1 << cfg_ring_log2);
        hdr = rd(UB);
        w0 = wr_count;
        issue(2'b00, id, len, 1'b0);
        chk(rd(UB + 4 + 8*slot) == id, {tag, " id word"}, rd(UB + 4 + 8*slot), id);
        chk(rd(UB + 8 + 8*slot) == len, {tag, " len word"}, rd(UB + 8 + 8*slot), len);
        chk(rd(UB) == hdr, "R2 header untouched by completion", rd(UB), hdr);
        chk(wr_count - w0 == 2, "R10 two writes per completion", 32'(wr_count - w0), 32'd2);
    endtask

    task automatic sync_check();
        logic [31:0] hdr;
        hdr = rd(UB);
        issue(2'b01, '0, '0, 1'b0);
        chk(rd(UB) == {16'(exp_next), hdr[15:0]}, "R3 published index", rd(UB), {16'(exp_next), hdr[15:0]});
    endtask

    task automatic clear_isr();
        @(negedge clk);
        isr_clear = 1'b1;
        @(posedge clk);
        #1 isr_clear = 1'b0;
        exp_irq = 1'b0; exp_isr = '0;
    endtask

    initial begin
        mem[UB >> 2] = 32'h1234_5A5A;
        mem[AB >> 2] = 32'h0000_0000;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_ready == 1'b1, "R1 ready", 32'(cmd_ready), 32'd1);
        chk(mem_req == 1'b0, "R1 no request", 32'(mem_req), 32'd0);
        chk(irq == 1'b0 && isr == 8'h0, "R1 interrupt clear", {24'h0, isr}, 32'h0);
        chk(next_used == 16'h0, "R1 next_used", 32'(next_used), 32'h0);

        put_check(32'd7, 32'd100, "R2 slot0");
        put_check(32'd9, 32'd200, "R2 slot1");

        // R4 no-interrupt bit clear: raise
        sync_check();
        chk(irq == 1'b1, "R4 raise on clear flag", 32'(irq), 32'd1);
        clear_isr();
        @(negedge clk);
        chk(irq == 1'b0, "R7 clear lowers irq", 32'(irq), 32'd0);

        // R6 suppressed, feature off: skip
        mem[AB >> 2] = 32'h0000_0001;
        sync_check();
        chk(irq == 1'b0, "R6 skip keeps irq low", 32'(irq), 32'd0);
        // feature on but queue not empty: skip
        cfg_notify_empty = 1'b1;
        sync_check();
        chk(cnt_skipped == 16'd2, "R6 skip with non-empty queue", 32'(cnt_skipped), 32'd2);
        // R5 feature on and queue empty: raise despite suppression
        queue_empty = 1'b1;
        sync_check();
        chk(irq == 1'b1, "R5 notify on empty overrides", 32'(irq), 32'd1);
        clear_isr();
        queue_empty = 1'b0;

        // wraparound in a ring of 4
        put_check(32'd11, 32'd300, "R2 slot2");
        put_check(32'd12, 32'd400, "R2 slot3");
        put_check(32'd13, 32'd500, "R2 wrap slot0");
        put_check(32'd14, 32'd600, "R2 wrap slot1");
        chk(rd(UB + 4) == 32'd13, "R2 slot0 overwritten", rd(UB + 4), 32'd13);

        // R8 kick control
        begin
            logic [31:0] h;
            h = rd(UB);
            issue(2'b10, '0, '0, 1'b0);
            chk(rd(UB) == (h | 32'h1), "R8 disable sets no-notify", rd(UB), h | 32'h1);
            issue(2'b10, '0, '0, 1'b1);
            chk(rd(UB) == (h & ~32'h1), "R8 enable clears no-notify", rd(UB), h & ~32'h1);
        end

        // R9 reserved opcode has no effect
        begin
            int w0;
            logic [31:0] h;
            w0 = wr_count; h = rd(UB);
            issue(2'b11, 32'hDEAD, 32'hBEEF, 1'b0);
            repeat (3) @(negedge clk);
            chk(wr_count == w0 && svc > 0, "R9 reserved op no write", 32'(wr_count), 32'(w0));
            chk(rd(UB) == h, "R9 reserved op header", rd(UB), h);
            chk(next_used == 16'(exp_next), "R9 reserved op index", 32'(next_used), 32'(exp_next));
        end

        // larger ring: slot 6 of 8
        cfg_ring_log2 = 4'd3;
        put_check(32'd21, 32'd700, "R2 ring8 slot6");
        mem[AB >> 2] = 32'h0000_0000;
        sync_check();
        chk(rd(UB)[31:16] == 16'd7, "R3 final index", 32'(rd(UB)[31:16]), 32'd7);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #50000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule